// File: doc/BRIEF.md
# Per-Lane Strobe Rising-Edge Search Engine

This block finds, for each byte lane of a memory interface, the delay setting at which a sampled strobe goes from 0 to 1. After a start pulse it programs every active lane to three coarse points: the initial delay plus 0, 1 and 2 times a fixed spacing of 26 phase steps. It requests one sample from an external sampler at each point. The three results for each lane form a 3-bit pattern. A fixed table maps that pattern to a starting delay and a search direction, and the table also covers the glitch patterns that a poor strobe duty cycle produces.

The fine phase then moves all active lanes together. It programs the delays, samples, and then moves each lane that has not yet found its edge by one phase step. Each lane's delay is exposed on its own output slice. An external encoder accepts the whole set through a program/acknowledge handshake, and no sample is requested until that handshake completes. The search ends with a one-cycle done pulse when every active lane has found its edge. If the number of fine samples reaches a limit first, the search ends with an error flag. In half-width mode only the lower half of the lanes takes part.

Top module: `edge_search_fsm`

## Requirements
- R1: After start, the delay of every active lane is presented at initial + k*26 for coarse sample k = 0, 1, 2, in that order, and each sample is requested only after that delay has been programmed.
- R2: A lane's pattern has coarse sample 0 in bit 2 and sample 2 in bit 0. The fine search starts at initial + 52 going forward for 000 and 100, at initial + 26 going forward for 001 and 101, at initial going forward for 010 and 011, and at initial going backward for 110 and 111.
- R3: In the fine phase, a forward lane whose sample bit (bit i of the sample vector is lane i, 1 meaning high) is 0 moves up by one step. A 1 ends that lane's search at its current delay.
- R4: A backward lane whose sample bit is 1 moves down by one step. A 0 ends that lane's search at its current delay.
- R5: A lane that has found its edge keeps its delay. When every active lane has found its edge, done_o is high for exactly one cycle with err_o low.
- R6: With half_width_i high at start, lanes NUM_LANES/2 and above are inactive. They hold the initial delay throughout, and their sample bits have no effect.
- R7: If MAX_ITER (default 64) fine samples complete without every active lane found, the search ends with done_o and err_o both high, after the step from the last sample is applied. err_o stays high until the next start.
- R8: prog_o and smp_req_o are never high together, and each one stays high until its acknowledge.
- R9: A start pulse during a search is ignored.
- R10: After reset, prog_o, smp_req_o, done_o and err_o are low and every delay output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a search (taken only when idle) |
| half_width_i | input | 1 | Only the lower half of the lanes is active |
| init_dly_i | input | NUM_LANES*DLY_W | Initial delay for each lane, lane i at bits [i*DLY_W +: DLY_W] |
| prog_o | output | 1 | Delay outputs are ready to be programmed |
| prog_ack_i | input | 1 | Encoder has taken the delays |
| dly_o | output | NUM_LANES*DLY_W | Current delay for each lane |
| smp_req_o | output | 1 | Request one strobe sample |
| smp_ack_i | input | 1 | Sample result is valid |
| smp_bits_i | input | NUM_LANES | Sampled strobe level for each lane |
| done_o | output | 1 | One-cycle end-of-search pulse |
| err_o | output | 1 | Search was aborted at the iteration limit |

## Verification
A delay change takes effect at the clock edge that accepts a sample acknowledge, or at the edge that leaves the classify state. The next prog_o is raised in the cycle after that edge, so the bench reads dly_o while a request is pending, never before. done_o and err_o rise in the cycle after the edge that accepts the final acknowledge. By then the last step is already visible on dly_o, and the final delays and flags are compared in that same cycle. The acknowledges are driven on falling edges with varied program latency, and every output is sampled on the falling edge. This keeps each comparison one registered stage after the edge that caused it.

// File: rtl/edge_search_pkg.sv
package edge_search_pkg;

  typedef enum logic [2:0] {
    LC_NOP,
    LC_LOAD,
    LC_SHIFT,
    LC_CLASS,
    LC_FINE
  } lane_cmd_e;

  // start offset, in units of the coarse spacing, chosen by a 3-bit pattern
  function automatic logic [1:0] pat_offset(input logic [2:0] p);
    case (p)
      3'b000, 3'b100: return 2'd2;
      3'b001, 3'b101: return 2'd1;
      default:        return 2'd0;
    endcase
  endfunction

  // only the two "high, high" patterns search downward
  function automatic logic pat_forward(input logic [2:0] p);
    return !(p[2] && p[1]);
  endfunction

  function automatic logic lane_active(input int idx, input int n, input logic half);
    return !half || (idx < n / 2);
  endfunction

endpackage

// File: rtl/edge_lane.sv
module edge_lane
  import edge_search_pkg::*;
#(
  parameter int DLY_W   = 9,
  parameter int SPACING = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active_i,
  input  lane_cmd_e        cmd_i,
  input  logic [1:0]       coarse_idx_i,
  input  logic             bit_i,
  input  logic [DLY_W-1:0] init_dly_i,
  output logic [DLY_W-1:0] dly_o,
  output logic             found_o,
  output logic             found_nx_o
);

  logic [DLY_W-1:0] base_q, dly_q, dly_nx;
  logic [2:0]       pat_q, pat_nx;
  logic             fwd_q, fwd_nx, found_q, found_nx;

  function automatic logic [DLY_W-1:0] at_offset(input logic [DLY_W-1:0] b,
                                                 input logic [1:0] idx);
    return b + DLY_W'(idx) * DLY_W'(SPACING);
  endfunction

  always_comb begin
    dly_nx   = dly_q;
    pat_nx   = pat_q;
    fwd_nx   = fwd_q;
    found_nx = found_q;
    case (cmd_i)
      LC_LOAD: begin
        dly_nx   = init_dly_i;
        pat_nx   = 3'b000;
        fwd_nx   = 1'b1;
        found_nx = 1'b0;
      end
      LC_SHIFT: begin
        pat_nx = {pat_q[1:0], bit_i};
        if (active_i) dly_nx = at_offset(base_q, coarse_idx_i);
      end
      LC_CLASS: begin
        fwd_nx   = pat_forward(pat_q);
        found_nx = !active_i;
        if (active_i) dly_nx = at_offset(base_q, pat_offset(pat_q));
      end
      LC_FINE: begin
        if (active_i && !found_q) begin
          if (fwd_q && !bit_i)       dly_nx = dly_q + 1'b1;
          else if (!fwd_q && bit_i)  dly_nx = dly_q - 1'b1;
          else                       found_nx = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      dly_q   <= '0;
      pat_q   <= '0;
      fwd_q   <= 1'b1;
      found_q <= 1'b0;
    end else begin
      if (cmd_i == LC_LOAD) base_q <= init_dly_i;
      dly_q   <= dly_nx;
      pat_q   <= pat_nx;
      fwd_q   <= fwd_nx;
      found_q <= found_nx;
    end
  end

  assign dly_o      = dly_q;
  assign found_o    = found_q;
  assign found_nx_o = found_nx;

  // R3/R4: a fine step moves the delay by at most one phase step
  assert_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == LC_FINE) |=> (dly_q == $past(dly_q) ||
                            dly_q == DLY_W'($past(dly_q) + 1'b1) ||
                            dly_q == DLY_W'($past(dly_q) - 1'b1)));

  assert_found_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (found_q && cmd_i == LC_FINE) |=> (found_q && $stable(dly_q)));

  assert_inactive_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_i && cmd_i != LC_LOAD) |=> $stable(dly_q));

endmodule

// File: rtl/edge_ctrl.sv
module edge_ctrl
  import edge_search_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int MAX_ITER  = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic                 half_i,
  input  logic                 prog_ack_i,
  input  logic                 smp_ack_i,
  input  logic [NUM_LANES-1:0] found_nx_i,
  output logic                 prog_o,
  output logic                 smp_req_o,
  output logic                 done_o,
  output logic                 err_o,
  output lane_cmd_e            lane_cmd_o,
  output logic [1:0]           coarse_idx_o,
  output logic [NUM_LANES-1:0] active_o
);

  localparam int IW = $clog2(MAX_ITER + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_CPROG, S_CSMP, S_CLASS, S_FPROG, S_FSMP, S_FIN
  } state_e;

  state_e         state_q;
  logic [1:0]     cnt_q;
  logic [IW-1:0]  iter_q;
  logic           half_q, err_q;
  logic           all_found, last_iter;

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_act
    assign active_o[i] = lane_active(i, NUM_LANES, half_q);
  end

  assign all_found    = &found_nx_i;
  assign last_iter    = (iter_q == IW'(MAX_ITER - 1));
  assign coarse_idx_o = cnt_q + 2'd1;
  assign prog_o       = (state_q == S_CPROG) || (state_q == S_FPROG);
  assign smp_req_o    = (state_q == S_CSMP)  || (state_q == S_FSMP);
  assign done_o       = (state_q == S_FIN);
  assign err_o        = err_q;

  always_comb begin
    lane_cmd_o = LC_NOP;
    case (state_q)
      S_IDLE:  if (start_i)   lane_cmd_o = LC_LOAD;
      S_CSMP:  if (smp_ack_i) lane_cmd_o = LC_SHIFT;
      S_CLASS:                lane_cmd_o = LC_CLASS;
      S_FSMP:  if (smp_ack_i) lane_cmd_o = LC_FINE;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      iter_q  <= '0;
      half_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: if (start_i) begin
          half_q  <= half_i;
          err_q   <= 1'b0;
          cnt_q   <= '0;
          iter_q  <= '0;
          state_q <= S_CPROG;
        end
        S_CPROG: if (prog_ack_i) state_q <= S_CSMP;
        S_CSMP: if (smp_ack_i) begin
          if (cnt_q == 2'd2) state_q <= S_CLASS;
          else begin
            cnt_q   <= cnt_q + 2'd1;
            state_q <= S_CPROG;
          end
        end
        S_CLASS: state_q <= S_FPROG;
        S_FPROG: if (prog_ack_i) state_q <= S_FSMP;
        S_FSMP: if (smp_ack_i) begin
          if (all_found) state_q <= S_FIN;
          else if (last_iter) begin
            err_q   <= 1'b1;
            state_q <= S_FIN;
          end else begin
            iter_q  <= iter_q + 1'b1;
            state_q <= S_FPROG;
          end
        end
        S_FIN:   state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assert_no_overlap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(prog_o && smp_req_o));

  assert_prog_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_o && !prog_ack_i) |=> prog_o);

  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_req_o && !smp_ack_i) |=> smp_req_o);

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_err_at_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> done_o);

  assert_busy_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != S_IDLE && start_i) |-> (lane_cmd_o != LC_LOAD));

endmodule

// File: rtl/edge_search_fsm.sv
module edge_search_fsm
  import edge_search_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int DLY_W     = 9,
  parameter int SPACING   = 26,
  parameter int MAX_ITER  = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  input  logic                       half_width_i,
  input  logic [NUM_LANES*DLY_W-1:0] init_dly_i,
  output logic                       prog_o,
  input  logic                       prog_ack_i,
  output logic [NUM_LANES*DLY_W-1:0] dly_o,
  output logic                       smp_req_o,
  input  logic                       smp_ack_i,
  input  logic [NUM_LANES-1:0]       smp_bits_i,
  output logic                       done_o,
  output logic                       err_o
);

  lane_cmd_e            lane_cmd;
  logic [1:0]           coarse_idx;
  logic [NUM_LANES-1:0] active, found, found_nx;

  edge_ctrl #(
    .NUM_LANES (NUM_LANES),
    .MAX_ITER  (MAX_ITER)
  ) ctrl_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .half_i       (half_width_i),
    .prog_ack_i   (prog_ack_i),
    .smp_ack_i    (smp_ack_i),
    .found_nx_i   (found_nx),
    .prog_o       (prog_o),
    .smp_req_o    (smp_req_o),
    .done_o       (done_o),
    .err_o        (err_o),
    .lane_cmd_o   (lane_cmd),
    .coarse_idx_o (coarse_idx),
    .active_o     (active)
  );

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    edge_lane #(
      .DLY_W   (DLY_W),
      .SPACING (SPACING)
    ) lane_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .active_i     (active[i]),
      .cmd_i        (lane_cmd),
      .coarse_idx_i (coarse_idx),
      .bit_i        (smp_bits_i[i]),
      .init_dly_i   (init_dly_i[i*DLY_W +: DLY_W]),
      .dly_o        (dly_o[i*DLY_W +: DLY_W]),
      .found_o      (found[i]),
      .found_nx_o   (found_nx[i])
    );
  end

  // R5: the search cannot finish cleanly while an active lane is still searching
  assert_clean_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !err_o) |-> (&found));

endmodule

// File: tb/edge_search_fsm_tb_top.sv
module edge_search_fsm_tb_top;

  localparam int NL = 4;
  localparam int DW = 9;
  localparam int SP = 26;
  localparam int MI = 64;

  typedef struct packed {
    logic [DW-1:0]          init;
    logic                   half;
    logic [NL-1:0][2:0]     pat;
    logic [NL-1:0][DW-1:0]  edg;
    logic [NL-1:0][DW-1:0]  expd;
    logic                   err;
  } vec_t;

  // lanes listed L3, L2, L1, L0
  localparam vec_t VECS [5] = '{
    '{9'd100, 1'b0, {3'b111, 3'b010, 3'b001, 3'b000},
      {9'd90, 9'd105, 9'd126, 9'd160}, {9'd89, 9'd105, 9'd126, 9'd160}, 1'b0},
    '{9'd100, 1'b1, {3'b000, 3'b000, 3'b101, 3'b110},
      {9'd400, 9'd400, 9'd130, 9'd97}, {9'd100, 9'd100, 9'd130, 9'd96}, 1'b0},
    '{9'd0, 1'b0, {3'b001, 3'b110, 3'b011, 3'b100},
      {9'd30, 9'd5, 9'd0, 9'd60}, {9'd30, 9'd0, 9'd0, 9'd60}, 1'b0},
    '{9'd10, 1'b0, {3'b101, 3'b011, 3'b111, 3'b000},
      {9'd40, 9'd0, 9'd8, 9'd500}, {9'd40, 9'd10, 9'd7, 9'd126}, 1'b1},
    '{9'd200, 1'b1, {3'b111, 3'b100, 3'b111, 3'b010},
      {9'd300, 9'd300, 9'd150, 9'd210}, {9'd200, 9'd200, 9'd149, 9'd210}, 1'b0}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start_i = 1'b0;
  logic              half_width_i = 1'b0;
  logic [NL*DW-1:0]  init_dly_i = '0;
  logic              prog_o, prog_ack_i = 1'b0;
  logic [NL*DW-1:0]  dly_o;
  logic              smp_req_o, smp_ack_i = 1'b0;
  logic [NL-1:0]     smp_bits_i = '0;
  logic              done_o, err_o;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  edge_search_fsm dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .half_width_i (half_width_i),
    .init_dly_i   (init_dly_i),
    .prog_o       (prog_o),
    .prog_ack_i   (prog_ack_i),
    .dly_o        (dly_o),
    .smp_req_o    (smp_req_o),
    .smp_ack_i    (smp_ack_i),
    .smp_bits_i   (smp_bits_i),
    .done_o       (done_o),
    .err_o        (err_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int lane_dly(input int i);
    return int'(dly_o[i*DW +: DW]);
  endfunction

  // own restatement of the start table: 0/4 -> two spacings, 1/5 -> one, rest -> none
  function automatic int start_ofs(input logic [2:0] p);
    int v = int'(p);
    if (v == 0 || v == 4) return 2 * SP;
    if (v == 1 || v == 5) return SP;
    return 0;
  endfunction

  task automatic run_vec(input vec_t v, input bit poke, input string tag);
    int  k = 0;
    int  pw = 0;
    int  guard = 0;
    bit  fin = 0;
    bit  act;
    @(negedge clk);
    for (int i = 0; i < NL; i++) init_dly_i[i*DW +: DW] = v.init;
    half_width_i = v.half;
    start_i = 1'b1;
    while (!fin) begin
      @(negedge clk);
      start_i = 1'b0;
      smp_ack_i = 1'b0;
      prog_ack_i = 1'b0;
      guard++;
      if (poke && (k == 4 || k == 6)) start_i = 1'b1;
      if (done_o) begin
        for (int i = 0; i < NL; i++) begin
          act = !v.half || i < NL / 2;
          check(lane_dly(i) == int'(v.expd[i]),
                poke ? "R9" : (!act ? "R6" : (v.pat[i][2] && v.pat[i][1]) ? "R4" : "R3"),
                $sformatf("%s final delay lane %0d", tag, i), lane_dly(i), int'(v.expd[i]));
        end
        check(err_o == v.err, v.err ? "R7" : "R5", {tag, " error flag"}, err_o, v.err);
        if (v.err) check(k - 3 == MI, "R7", {tag, " fine samples before abort"}, k - 3, MI);
        fin = 1;
        @(negedge clk);
        check(!done_o, "R5", {tag, " done is one cycle"}, done_o, 0);
      end else if (smp_req_o) begin
        check(!prog_o, "R8", {tag, " program idle at request"}, prog_o, 0);
        for (int i = 0; i < NL; i++) begin
          act = !v.half || i < NL / 2;
          if (!act)
            check(lane_dly(i) == int'(v.init), "R6", $sformatf("%s idle lane %0d", tag, i),
                  lane_dly(i), int'(v.init));
          else if (k < 3)
            check(lane_dly(i) == (int'(v.init) + k * SP) % (1 << DW), "R1",
                  $sformatf("%s coarse %0d lane %0d", tag, k, i), lane_dly(i),
                  (int'(v.init) + k * SP) % (1 << DW));
          else if (k == 3)
            check(lane_dly(i) == int'(v.init) + start_ofs(v.pat[i]), "R2",
                  $sformatf("%s fine start lane %0d", tag, i), lane_dly(i),
                  int'(v.init) + start_ofs(v.pat[i]));
        end
        for (int i = 0; i < NL; i++)
          smp_bits_i[i] = (k < 3) ? v.pat[i][2 - k] : (lane_dly(i) >= int'(v.edg[i]));
        smp_ack_i = 1'b1;
        k++;
      end else if (prog_o) begin
        if (pw == 0) begin
          prog_ack_i = 1'b1;
          pw = k % 3;
        end else pw--;
      end
      if (guard > 3000) begin
        check(0, "R5", {tag, " search never ended"}, guard, 0);
        fin = 1;
      end
    end
    smp_ack_i = 1'b0;
    prog_ack_i = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    check(0, "R5", "watchdog expired", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check(!prog_o && !smp_req_o, "R10", "handshake outputs after reset", {prog_o, smp_req_o}, 0);
    check(!done_o && !err_o, "R10", "done/error after reset", {done_o, err_o}, 0);
    check(dly_o == '0, "R10", "delays after reset", int'(dly_o[DW-1:0]), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!prog_o && !smp_req_o && !done_o, "R10", "idle without start",
          {prog_o, smp_req_o, done_o}, 0);

    for (int n = 0; n < 5; n++) run_vec(VECS[n], 1'b0, $sformatf("vec%0d", n));

    // R9: start pulses mid-search leave the result unchanged
    run_vec(VECS[2], 1'b1, "busy-start");
    // R7 then R5: abort followed by a clean run clears the flag
    run_vec(VECS[3], 1'b0, "abort-again");
    run_vec(VECS[0], 1'b0, "after-abort");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule